// File: doc/BRIEF.md
# H-Bridge Shoot-Through Guard with Dead Time

This block sits between a microcontroller and the four gate-control lines of a full H-bridge. Each bridge leg has one high-side and one low-side switch. The block ensures at logic level that a leg can never be shorted, even when the controller software misbehaves.

The block has two command modes, chosen by `raw_sel`. In polarity mode, one `polarity` bit sets the direction and the complementary drive for both legs is derived from it. In raw mode, the four switch requests arrive on separate lines. Any raw request that asks for both switches of one leg turns all four outputs off and sets a sticky fault flag.

Every output is gated by `drive_en`. When that enable is low, or while reset is held, nothing conducts. Whenever a request changes, the switch that is turning off drops at once. The opposite switch asserts only after a programmable quiet interval of `DEAD_CYC` clock cycles. All asynchronous inputs except `fault_clr` pass through a synchroniser of `SYNC_STAGES` flops, and both legs see the same latency.

Top module: `hbridge_guard`

## Requirements
The figures below use the defaults `SYNC_STAGES` = 2 and `DEAD_CYC` = D. Edge 1 is the first rising clock edge after an input pin changes.
- R1: The high-side and low-side outputs of one leg are never high at the same time. Leg A is `gate_on[0]` (high side) and `gate_on[1]` (low side). Leg B is `gate_on[2]` (high side) and `gate_on[3]` (low side).
- R2: When the requested drive changes, a switch that is on is released at edge 3. The newly requested switch asserts at edge D+4. Both outputs of the leg are therefore low for exactly D+1 cycles.
- R3: In polarity mode (`raw_sel`=0), `polarity`=1 requests A-high with B-low, so `gate_on`=4'b1001. `polarity`=0 requests A-low with B-high, so `gate_on`=4'b0110.
- R4: When `drive_en` goes low, all outputs drop right after edge 2. When `drive_en` returns high, outputs stay low until they assert at edge D+4.
- R5: In raw mode (`raw_sel`=1), the `raw_cmd` bits use the same bit positions as `gate_on`. A command in which no leg has both of its bits set is reproduced on `gate_on` once the dead interval has elapsed.
- R6: A raw command with both bits of either leg set (bits 0 and 1, or bits 2 and 3) forces all four outputs low at edge 3, including the outputs of the other leg.
- R7: `fault` goes high at edge 3 after an illegal raw command. It stays high until `fault_clr` is sampled high on a clock edge while no illegal command is present; a new illegal command takes priority over a clear. Reset also clears `fault`.
- R8: While `rst_n` is low, `gate_on` is 0 and `fault` is 0. After reset is released with a drive already requested, the first switch asserts at the (D+4)-th rising edge.
- R9: If the request changes again before the opposite switch has turned on, the quiet interval restarts. Neither switch of the reversed pair asserts in between, and the original drive returns at edge D+4 counted from the last change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Drive enable (asynchronous); low means all off |
| polarity | input | 1 | Direction in polarity mode (asynchronous) |
| raw_sel | input | 1 | 1 selects raw four-line mode (asynchronous) |
| raw_cmd | input | 4 | Raw switch requests, same bit order as gate_on (asynchronous) |
| fault_clr | input | 1 | Synchronous clear of the fault flag |
| gate_on | output | 4 | Switch-on lines: [0] A high, [1] A low, [2] B high, [3] B low |
| fault | output | 1 | Sticky flag for illegal raw commands |

## Verification
Each leg holds only two on-bits, a quiet counter and the last request it saw. A corrupted value in any of them shows up at the ports within a handful of cycles:
- A quiet counter that is wrong moves the turn-on edge away from D+4, and the exact-edge checks catch this at once.
- A wrong transition rule gives an early opposite turn-on, which would show as 4'b0110 inside a glitch window.
- A missed clear of the on-bits leaves a leg high after an illegal command or after the enable drops.
- A broken fault latch shows within the three edges after an illegal command or a clear.

The bench sweeps all 16 raw command codes and every glitch width up to D+1, and checks each exact edge.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

   // Number of bridge legs in a full bridge and the width of the four-line command.
   localparam int NUM_LEGS = 2;
   localparam int CMD_W    = 2 * NUM_LEGS;

   // Request for one leg: which of its two switches should conduct.
   typedef enum logic [1:0] {
      LEG_OFF = 2'b00,
      LEG_HI  = 2'b01,
      LEG_LO  = 2'b10
   } leg_req_e;

endpackage

// File: rtl/hbg_sync.sv
`timescale 1ns/1ps
module hbg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("hbg_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("hbg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hbg_decode.sv
`timescale 1ns/1ps
module hbg_decode
   import hbg_pkg::*;
(
   input  logic            pol,
   input  logic            raw_mode,
   input  logic [CMD_W-1:0] cmd,
   output leg_req_e        req [NUM_LEGS],
   output logic            illegal
);

   logic [NUM_LEGS-1:0] pair_bad;
   leg_req_e            raw_req [NUM_LEGS];
   leg_req_e            pol_req [NUM_LEGS];

   for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
      // Both switches of this leg requested together.
      assign pair_bad[i] = cmd[2*i] & cmd[2*i+1];

      always_comb begin
         unique case ({cmd[2*i+1], cmd[2*i]})
            2'b01:   raw_req[i] = LEG_HI;
            2'b10:   raw_req[i] = LEG_LO;
            default: raw_req[i] = LEG_OFF;
         endcase
      end

      // Even legs follow the polarity bit on their high side, odd legs on their low side.
      if ((i % 2) == 0) begin : g_even
         assign pol_req[i] = pol ? LEG_HI : LEG_LO;
      end else begin : g_odd
         assign pol_req[i] = pol ? LEG_LO : LEG_HI;
      end
   end

   assign illegal = raw_mode & (|pair_bad);

   // Any illegal pair blanks every leg, not just the offending one.
   for (genvar i = 0; i < NUM_LEGS; i++) begin : g_sel
      always_comb begin
         if (!raw_mode) begin
            req[i] = pol_req[i];
         end else if (illegal) begin
            req[i] = LEG_OFF;
         end else begin
            req[i] = raw_req[i];
         end
      end
   end

endmodule

// File: rtl/hbg_leg.sv
`timescale 1ns/1ps
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int DEAD_CYC = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  leg_req_e req,
   output logic     gate_hi,
   output logic     gate_lo
);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hbg_leg: DEAD_CYC must be at least 1");
   end

   localparam int              CNT_W   = $clog2(DEAD_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEAD_CYC);

   logic             on_hi_q, on_lo_q;
   logic             on_hi_d, on_lo_d;
   logic [CNT_W-1:0] quiet_q, quiet_d;
   logic             en_prev_q;
   leg_req_e         req_prev_q;
   logic             ctx_moved;
   logic             any_on;
   logic             may_start;

   assign any_on    = on_hi_q | on_lo_q;
   assign ctx_moved = (en != en_prev_q) || (req != req_prev_q);

   // Quiet counter: cycles with the leg fully off and an unchanged request.
   always_comb begin
      if (any_on || !en || ctx_moved) begin
         quiet_d = '0;
      end else if (quiet_q == CNT_MAX) begin
         quiet_d = quiet_q;
      end else begin
         quiet_d = quiet_q + CNT_W'(1);
      end
   end

   assign may_start = en && !any_on && !ctx_moved &&
                      (quiet_q == CNT_MAX) && (req != LEG_OFF);

   always_comb begin
      on_hi_d = on_hi_q;
      on_lo_d = on_lo_q;
      if (!en) begin
         on_hi_d = 1'b0;
         on_lo_d = 1'b0;
      end else begin
         if (on_hi_q && (req != LEG_HI)) on_hi_d = 1'b0;
         if (on_lo_q && (req != LEG_LO)) on_lo_d = 1'b0;
         if (may_start) begin
            on_hi_d = (req == LEG_HI);
            on_lo_d = (req == LEG_LO);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_hi_q    <= 1'b0;
         on_lo_q    <= 1'b0;
         quiet_q    <= '0;
         en_prev_q  <= 1'b0;
         req_prev_q <= LEG_OFF;
      end else begin
         on_hi_q    <= on_hi_d;
         on_lo_q    <= on_lo_d;
         quiet_q    <= quiet_d;
         en_prev_q  <= en;
         req_prev_q <= req;
      end
   end

   assign gate_hi = on_hi_q & en;
   assign gate_lo = on_lo_q & en;

   // Independent run-length of fully-off cycles, used to check the dead gap.
   localparam int               RUN_W   = $clog2(DEAD_CYC + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEAD_CYC + 1);
   logic [RUN_W-1:0] off_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_run_q <= '0;
      end else if (gate_hi || gate_lo) begin
         off_run_q <= '0;
      end else if (off_run_q != RUN_MAX) begin
         off_run_q <= off_run_q + RUN_W'(1);
      end
   end

   AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo)) else $error("leg shorted"); // R1

   AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> !$past(gate_lo)) else $error("high on before low off"); // R2

   AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> !$past(gate_hi)) else $error("low on before high off"); // R2

   AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run_q == RUN_MAX))
      else $error("dead interval too short"); // R2

endmodule

// File: rtl/hbg_fault.sv
`timescale 1ns/1ps
module hbg_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // Set dominates clear so a persisting illegal command cannot be hidden.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o) else $error("fault dropped without clear"); // R7

   AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o) else $error("fault not set"); // R7

endmodule

// File: rtl/hbridge_guard.sv
`timescale 1ns/1ps
module hbridge_guard
   import hbg_pkg::*;
#(
   parameter int DEAD_CYC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive_en,
   input  logic             polarity,
   input  logic             raw_sel,
   input  logic [CMD_W-1:0] raw_cmd,
   input  logic             fault_clr,
   output logic [CMD_W-1:0] gate_on,
   output logic             fault
);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hbridge_guard: DEAD_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hbridge_guard: SYNC_STAGES must be at least 2");
   end

   localparam int SYNC_W = CMD_W + 3;

   logic [SYNC_W-1:0] async_in;
   logic [SYNC_W-1:0] sync_out;
   logic              en_s, pol_s, mode_s;
   logic [CMD_W-1:0]  cmd_s;
   leg_req_e          leg_req [NUM_LEGS];
   logic              illegal_s;

   assign async_in = {raw_cmd, raw_sel, polarity, drive_en};

   hbg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in),
      .q     (sync_out)
   );

   assign en_s   = sync_out[0];
   assign pol_s  = sync_out[1];
   assign mode_s = sync_out[2];
   assign cmd_s  = sync_out[SYNC_W-1:3];

   hbg_decode u_decode (
      .pol      (pol_s),
      .raw_mode (mode_s),
      .cmd      (cmd_s),
      .req      (leg_req),
      .illegal  (illegal_s)
   );

   for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
      hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_s),
         .req     (leg_req[i]),
         .gate_hi (gate_on[2*i]),
         .gate_lo (gate_on[2*i+1])
      );
   end

   hbg_fault u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (illegal_s),
      .clr_i  (fault_clr),
      .flag_o (fault)
   );

   AST_ILLEGAL_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_s |=> (gate_on == '0)) else $error("illegal command left a switch on"); // R6

   AST_ENABLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_s) |=> (gate_on == '0)) else $error("switch on without dead wait"); // R4

   AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_s) |-> (gate_on == '0)) else $error("switch on while disabled"); // R4

endmodule

// File: tb/hbridge_guard_bench.sv
`timescale 1ns/1ps
module hbridge_guard_bench;

   localparam int DEAD = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       drive_en, polarity, raw_sel, fault_clr;
   logic [3:0] raw_cmd;
   logic [3:0] gate_on;
   logic       fault;

   int checks   = 0;
   int failures = 0;
   int overlap  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   hbridge_guard #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) u_hbridge_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive_en  (drive_en),
      .polarity  (polarity),
      .raw_sel   (raw_sel),
      .raw_cmd   (raw_cmd),
      .fault_clr (fault_clr),
      .gate_on   (gate_on),
      .fault     (fault)
   );

   // R1: count any cycle where a leg has both switches on.
   always @(negedge clk) begin
      if ((gate_on[0] && gate_on[1]) || (gate_on[2] && gate_on[3])) overlap++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // R2/R3: reverse polarity and check exact release and turn-on edges.
   task automatic reverse(input logic new_pol, input logic [3:0] old_v, input logic [3:0] new_v);
      polarity = new_pol;
      tick(2);
      chk("R2 still on before edge 3", gate_on, old_v);
      tick(1);
      chk("R2 released at edge 3", gate_on, 4'b0000);
      for (int j = 0; j < DEAD; j++) begin
         tick(1);
         chk("R2 dead interval", gate_on, 4'b0000);
      end
      tick(1);
      chk("R2 R3 opposite on at edge D+4", gate_on, new_v);
   endtask

   initial begin
      rst_n = 1'b0; drive_en = 1'b1; polarity = 1'b1; raw_sel = 1'b0;
      raw_cmd = 4'b0000; fault_clr = 1'b0;
      tick(3);
      chk("R8 outputs off in reset", gate_on, 4'b0000);
      chk("R8 fault clear in reset", fault, 1'b0);
      rst_n = 1'b1;
      for (int j = 0; j < DEAD + 3; j++) begin
         tick(1);
         chk("R8 off after reset release", gate_on, 4'b0000);
      end
      tick(1);
      chk("R8 R3 first on at edge D+4", gate_on, 4'b1001);

      reverse(1'b0, 4'b1001, 4'b0110);
      reverse(1'b1, 4'b0110, 4'b1001);

      // R9: glitches of every width up to D+1 cycles.
      for (int w = 1; w <= DEAD + 1; w++) begin
         polarity = 1'b0;
         tick(w);
         polarity = 1'b1;
         for (int j = 0; j < DEAD + 3; j++) begin
            tick(1);
            chk("R9 no opposite drive in glitch", (gate_on == 4'b0110), 1'b0);
         end
         chk("R9 still off before restart ends", gate_on, 4'b0000);
         tick(1);
         chk("R9 original drive back at D+4", gate_on, 4'b1001);
      end

      // R4: enable removal and restoration.
      drive_en = 1'b0;
      tick(1);
      chk("R4 on before edge 2", gate_on, 4'b1001);
      tick(1);
      chk("R4 off at edge 2", gate_on, 4'b0000);
      tick(5);
      chk("R4 stays off while disabled", gate_on, 4'b0000);
      drive_en = 1'b1;
      for (int j = 0; j < DEAD + 3; j++) begin
         tick(1);
         chk("R4 waits after enable", gate_on, 4'b0000);
      end
      tick(1);
      chk("R4 on at edge D+4 after enable", gate_on, 4'b1001);

      // R5: raw mode with the same pattern keeps driving.
      raw_cmd = 4'b1001;
      raw_sel = 1'b1;
      tick(DEAD + 8);
      chk("R5 raw pattern 1001", gate_on, 4'b1001);

      // R6/R7: illegal command timing, priority over clear, stickiness.
      raw_cmd = 4'b1011;
      tick(2);
      chk("R6 on before edge 3", gate_on, 4'b1001);
      chk("R7 fault low before edge 3", fault, 1'b0);
      tick(1);
      chk("R6 all off at edge 3", gate_on, 4'b0000);
      chk("R7 fault set at edge 3", fault, 1'b1);
      fault_clr = 1'b1;
      tick(1);
      fault_clr = 1'b0;
      chk("R7 set beats clear", fault, 1'b1);
      raw_cmd = 4'b0000;
      tick(4);
      chk("R7 fault sticky", fault, 1'b1);
      fault_clr = 1'b1;
      tick(1);
      fault_clr = 1'b0;
      chk("R7 fault cleared", fault, 1'b0);

      // R5/R6/R7: sweep all raw codes.
      for (int c = 0; c < 16; c++) begin
         logic [3:0] cv;
         logic       bad;
         cv  = 4'(c);
         bad = (cv[0] & cv[1]) | (cv[2] & cv[3]);
         raw_cmd = cv;
         tick(DEAD + 8);
         chk(bad ? "R6 sweep illegal code" : "R5 sweep legal code", gate_on, bad ? 4'b0000 : cv);
         chk("R7 sweep fault", fault, bad);
         raw_cmd = 4'b0000;
         tick(3);
         chk("R7 sweep fault held", fault, bad);
         fault_clr = 1'b1;
         tick(1);
         fault_clr = 1'b0;
         chk("R7 sweep fault cleared", fault, 1'b0);
      end

      chk("R1 no leg overlap observed", overlap, 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule